// File: doc/BRIEF.md
# GPIO port with interrupt detection

This block is one general-purpose pin port of a configurable width. It holds, per pin, a direction bit, an output data bit, a pull-up enable and two independent alternate-function select bits. It presents these straight to the pad ring and samples the incoming pin levels through a two-stage synchroniser. A simple synchronous register bus writes in one cycle and reads combinationally in the same cycle. Register bits above the implemented pin count are dropped on write and read back as zero.

Every pin also carries an interrupt trigger. A three-bit mode code selects rising edge, falling edge, both edges, high level or low level, or no trigger. The code is split across three registers. Edge events are latched in a status register that software clears by writing ones. Level events show in the status view only while the level lasts. A per-pin enable gates each status bit onto the port's single interrupt line. The enable has one address that sets bits and another that clears them.

External interrupt lines are numbered globally across two port instances, and the numbering does not follow pin order. A command input takes such a number with a mode. When the number lands on an implemented pin of this port, the pin's mode bits are replaced and its enable is set. The command can also just withdraw the enable.

Top module: `pinbank_irq`

## Requirements
- R1: After reset every configuration, mode, enable and status register reads zero, all pins are inputs (`pin_oe` zero) and `irq` is low.
- R2: Word addresses are 0 direction, 1 output data, 3 pull-up, 4 alternate select A, 5 alternate select B. Each is written by `bus_we` and read back on `bus_rdata` in the same cycle its address is presented. Direction bit 1 makes the pin an output on `pin_oe`. The other four drive `pin_out`, `pin_pull`, `pin_alt_a` and `pin_alt_b` from the cycle after the write.
- R3: `bus_wdata` bits at or above `NUM_PINS` are ignored, and every register read returns zero in those bits.
- R4: Address 2 reads the pin levels after two register stages. A change on `pin_in` before clock edge k is visible after edge k+1 and not after edge k. Writes to address 2 have no effect.
- R5: The pin mode is {address 8 bit, address 7 bit, address 6 bit}. Mode 1 latches a rising edge, mode 2 a falling edge and mode 3 either edge into the status register at address 11. An edge on a pin that has settled for two edges shows in status after the third clock edge following the pin change.
- R6: Mode 5 shows a status bit while the synchronised pin is high, and mode 6 while it is low. Neither is latched, so the bit drops when the level goes away. Modes 0, 4 and 7 produce no event.
- R7: Writing address 11 clears latched status bits where the data has ones and leaves bits where it has zeros. A latched bit stays set until cleared that way.
- R8: A write to address 9 sets enable bits where the data has ones, and a write to address 10 clears enable bits where it has ones. Zeros leave the enable unchanged, and both addresses read the enable.
- R9: `irq` is high exactly when some status bit (latched edge or live level) has its enable set.
- R10: The external-interrupt numbers map as follows. 0..10 go to port 0 pins 7..17. 11..14 go to port 1 pins 18..15 (descending). 15 goes to port 1 pin 19, and 16 to port 0 pin 19. All other numbers are invalid.
- R11: A `cfg_req` with `cfg_en`=1 and a number that maps to this `PORT_ID` and an implemented pin replaces that pin's three mode bits with `cfg_mode` and sets its enable. Mode 7 is refused. With `cfg_en`=0 only the pin's enable is cleared. Invalid numbers, other ports and unimplemented pins change nothing. A command takes precedence over a bus write to the same bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| cfg_req | input | 1 | External-interrupt command strobe |
| cfg_en | input | 1 | 1 programs mode and enables, 0 only disables |
| cfg_xint | input | 5 | Global external-interrupt number |
| cfg_mode | input | 3 | Trigger mode code for the command |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pin_out | output | NUM_PINS | Output data to the pads |
| pin_oe | output | NUM_PINS | Output enable, 1 = driven |
| pin_pull | output | NUM_PINS | Pull-up enable per pin |
| pin_alt_a | output | NUM_PINS | Alternate-function select A |
| pin_alt_b | output | NUM_PINS | Alternate-function select B |
| irq | output | 1 | Port interrupt, OR of enabled status |

## Verification
The bench builds two instances side by side. One is a 20-pin port with `PORT_ID` 0 and the other a 19-pin port with `PORT_ID` 1, and both receive every command. The two widths make the upper-bit masking differ between instances. Every map entry lands on one port while the other must stay untouched. Number 15 points at pin 19 of port 1, which the 19-pin instance does not implement, so that command must change nothing.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int ADDR_W  = 4;
    localparam int XINT_W  = 5;
    localparam int PIDX_W  = 5;

    // Word addresses of the port register file
    typedef enum logic [ADDR_W-1:0] {
        RA_DIR  = 4'd0,
        RA_OUT  = 4'd1,
        RA_IN   = 4'd2,
        RA_PULL = 4'd3,
        RA_ALTA = 4'd4,
        RA_ALTB = 4'd5,
        RA_TRG0 = 4'd6,
        RA_TRG1 = 4'd7,
        RA_TLVL = 4'd8,
        RA_IENS = 4'd9,
        RA_IENC = 4'd10,
        RA_STAT = 4'd11
    } reg_addr_e;

    // Mode code refused by the command path
    localparam logic [2:0] MODE_REFUSED = 3'd7;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = async_in;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.s2;
    assign prev_o = sy_q.prev;
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect #(
    parameter int W = 20
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] m_rise,
    input  logic [W-1:0] m_fall,
    input  logic [W-1:0] m_lvl,
    output logic [W-1:0] edge_hit,
    output logic [W-1:0] lvl_hit
);
    // Per pin: with the level bit clear, the two low mode bits pick
    // rising and falling edges. With it set, exactly one low bit must
    // be set, choosing high (bit 0) or low (bit 1) level.
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rose, fell, one_hot;
        assign rose        = cur[i] & ~prev[i];
        assign fell        = ~cur[i] & prev[i];
        assign one_hot     = m_rise[i] ^ m_fall[i];
        assign edge_hit[i] = ~m_lvl[i] & ((m_rise[i] & rose) | (m_fall[i] & fell));
        assign lvl_hit[i]  = m_lvl[i] & one_hot &
                             (m_rise[i] ? cur[i] : ~cur[i]);
    end
endmodule

// File: rtl/pinbank_xint_map.sv
module pinbank_xint_map
    import pinbank_pkg::*;
(
    input  logic [XINT_W-1:0] xint,
    output logic              valid,
    output logic              port,
    output logic [PIDX_W-1:0] pin
);
    always_comb begin
        valid = 1'b1;
        port  = 1'b0;
        pin   = '0;
        if (xint <= 5'd10) begin
            pin = xint + 5'd7;
        end else if (xint <= 5'd14) begin
            port = 1'b1;
            pin  = 5'd29 - xint;
        end else if (xint == 5'd15) begin
            port = 1'b1;
            pin  = 5'd19;
        end else if (xint == 5'd16) begin
            pin  = 5'd19;
        end else begin
            valid = 1'b0;
        end
    end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int PORT_ID  = 0,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                cfg_req,
    input  logic                cfg_en,
    input  logic [XINT_W-1:0]   cfg_xint,
    input  logic [2:0]          cfg_mode,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pull,
    output logic [NUM_PINS-1:0] pin_alt_a,
    output logic [NUM_PINS-1:0] pin_alt_b,
    output logic                irq
);
    localparam int                W       = NUM_PINS;
    localparam logic [PIDX_W:0]   PIN_LIM = (PIDX_W+1)'(NUM_PINS);
    localparam logic              MY_PORT = 1'(PORT_ID);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] pull;
        logic [W-1:0] alt_a;
        logic [W-1:0] alt_b;
        logic [W-1:0] trg0;
        logic [W-1:0] trg1;
        logic [W-1:0] tlvl;
        logic [W-1:0] ien;
        logic [W-1:0] evt;
    } regs_t;

    regs_t st_d, st_q;

    logic [W-1:0]        wdat;
    logic [DATA_W-1:W]   unused_hi;
    logic [W-1:0]        in_sync, in_prev;
    logic [W-1:0]        edge_hit, lvl_hit;
    logic                map_valid, map_port;
    logic [PIDX_W-1:0]   map_pin;
    logic                cmd_hit;
    logic [W-1:0]        sel;
    logic [W-1:0]        rd_w;
    logic [W-1:0]        ien_vec, evt_vec;

    assign wdat      = bus_wdata[W-1:0];
    assign unused_hi = bus_wdata[DATA_W-1:W];

    pinbank_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_o   (in_sync),
        .prev_o   (in_prev)
    );

    pinbank_detect #(.W(W)) u_detect (
        .cur      (in_sync),
        .prev     (in_prev),
        .m_rise   (st_q.trg0),
        .m_fall   (st_q.trg1),
        .m_lvl    (st_q.tlvl),
        .edge_hit (edge_hit),
        .lvl_hit  (lvl_hit)
    );

    pinbank_xint_map u_map (
        .xint  (cfg_xint),
        .valid (map_valid),
        .port  (map_port),
        .pin   (map_pin)
    );

    // Command acceptance: number must land on an implemented pin of this port
    always_comb begin
        sel     = W'(1) << map_pin;
        cmd_hit = cfg_req && map_valid && (map_port == MY_PORT) &&
                  ({1'b0, map_pin} < PIN_LIM) &&
                  !(cfg_en && (cfg_mode == MODE_REFUSED));
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            case (bus_addr)
                RA_DIR:  st_d.dir   = wdat;
                RA_OUT:  st_d.dout  = wdat;
                RA_PULL: st_d.pull  = wdat;
                RA_ALTA: st_d.alt_a = wdat;
                RA_ALTB: st_d.alt_b = wdat;
                RA_TRG0: st_d.trg0  = wdat;
                RA_TRG1: st_d.trg1  = wdat;
                RA_TLVL: st_d.tlvl  = wdat;
                RA_IENS: st_d.ien   = st_q.ien | wdat;
                RA_IENC: st_d.ien   = st_q.ien & ~wdat;
                RA_STAT: st_d.evt   = st_q.evt & ~wdat;
                default: ;
            endcase
        end
        // A fresh edge wins over a clear in the same cycle
        st_d.evt = st_d.evt | edge_hit;
        // Command overrides any bus write to the same bits
        if (cmd_hit) begin
            if (cfg_en) begin
                st_d.trg0 = (st_d.trg0 & ~sel) | (cfg_mode[0] ? sel : '0);
                st_d.trg1 = (st_d.trg1 & ~sel) | (cfg_mode[1] ? sel : '0);
                st_d.tlvl = (st_d.tlvl & ~sel) | (cfg_mode[2] ? sel : '0);
                st_d.ien  = st_d.ien | sel;
            end else begin
                st_d.ien  = st_d.ien & ~sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        case (bus_addr)
            RA_DIR:  rd_w = st_q.dir;
            RA_OUT:  rd_w = st_q.dout;
            RA_IN:   rd_w = in_sync;
            RA_PULL: rd_w = st_q.pull;
            RA_ALTA: rd_w = st_q.alt_a;
            RA_ALTB: rd_w = st_q.alt_b;
            RA_TRG0: rd_w = st_q.trg0;
            RA_TRG1: rd_w = st_q.trg1;
            RA_TLVL: rd_w = st_q.tlvl;
            RA_IENS: rd_w = st_q.ien;
            RA_IENC: rd_w = st_q.ien;
            RA_STAT: rd_w = st_q.evt | lvl_hit;
            default: rd_w = '0;
        endcase
        bus_rdata        = '0;
        bus_rdata[W-1:0] = rd_w;
    end

    assign pin_out   = st_q.dout;
    assign pin_oe    = st_q.dir;
    assign pin_pull  = st_q.pull;
    assign pin_alt_a = st_q.alt_a;
    assign pin_alt_b = st_q.alt_b;
    assign irq       = |((st_q.evt | lvl_hit) & st_q.ien);

    assign ien_vec   = st_q.ien;
    assign evt_vec   = st_q.evt;
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
    import pinbank_pkg::*;
#(
    parameter int W      = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      wdat,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cfg_req,
    input logic [W-1:0]      pin_oe,
    input logic              irq,
    input logic [W-1:0]      ien_vec,
    input logic [W-1:0]      evt_vec
);
    // R1: state is clear on the first cycle out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ien_vec == '0 && evt_vec == '0 && pin_oe == '0));

    // R2: direction only changes after a direction write
    a_r2_dir_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(bus_we && bus_addr == RA_DIR));

    // R3: bits above the port width read zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata >> W) == '0);

    // R7: latched events persist unless a status write happens
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == RA_STAT) |=>
        ((evt_vec & $past(evt_vec)) == $past(evt_vec)));

    // R8: set address sets every written one
    a_r8_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_IENS && !cfg_req) |=>
        ((ien_vec & $past(wdat)) == $past(wdat)));

    // R8: clear address clears every written one
    a_r8_clr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_IENC && !cfg_req) |=>
        ((ien_vec & $past(wdat)) == '0));

    // R9: no enable, no interrupt
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_vec == '0) |-> !irq);
endmodule

bind pinbank_irq pinbank_irq_chk #(.W(NUM_PINS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wdat      (bus_wdata[NUM_PINS-1:0]),
    .bus_rdata (bus_rdata),
    .cfg_req   (cfg_req),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .ien_vec   (ien_vec),
    .evt_vec   (evt_vec)
);

// File: tb/pinbank_irq_bench.sv
module pinbank_irq_bench;
    import pinbank_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        cfg_req = 1'b0, cfg_en = 1'b0;
    logic [4:0]  cfg_xint = '0;
    logic [2:0]  cfg_mode = '0;
    logic [19:0] in_a = '0;
    logic [18:0] in_b = '0;
    logic [19:0] out_a, oe_a, pull_a, alta_a, altb_a;
    logic [18:0] out_b, oe_b, pull_b, alta_b, altb_b;
    logic        irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pinbank_irq #(.NUM_PINS(20), .PORT_ID(0)) u_pinbank_irq (
        .clk(clk), .rst_n(rst_n), .bus_we(we_a), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .cfg_req(cfg_req),
        .cfg_en(cfg_en), .cfg_xint(cfg_xint), .cfg_mode(cfg_mode),
        .pin_in(in_a), .pin_out(out_a), .pin_oe(oe_a), .pin_pull(pull_a),
        .pin_alt_a(alta_a), .pin_alt_b(altb_a), .irq(irq_a));

    pinbank_irq #(.NUM_PINS(19), .PORT_ID(1)) u_pinbank_irq_p1 (
        .clk(clk), .rst_n(rst_n), .bus_we(we_b), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .cfg_req(cfg_req),
        .cfg_en(cfg_en), .cfg_xint(cfg_xint), .cfg_mode(cfg_mode),
        .pin_in(in_b), .pin_out(out_b), .pin_oe(oe_b), .pin_pull(pull_b),
        .pin_alt_a(alta_b), .pin_alt_b(altb_b), .irq(irq_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit port_b, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (port_b) we_b = 1'b1; else we_a = 1'b1;
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0;
    endtask

    task automatic rd(input bit port_b, input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = port_b ? rdata_b : rdata_a;
    endtask

    task automatic cmd(input logic [4:0] x, input logic [2:0] m, input bit en);
        @(negedge clk);
        cfg_req = 1'b1; cfg_xint = x; cfg_mode = m; cfg_en = en;
        @(negedge clk);
        cfg_req = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, RA_DIR, v);  chk("R1 dir after reset", v, 32'h0);
        rd(0, RA_IENS, v); chk("R1 enable after reset", v, 32'h0);
        rd(0, RA_STAT, v); chk("R1 status after reset", v, 32'h0);
        rd(0, RA_TRG0, v); chk("R1 mode bit0 after reset", v, 32'h0);
        chk("R1 pin_oe after reset", {12'h0, oe_a}, 32'h0);
        chk("R1 irq after reset", {31'h0, irq_a}, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(0, RA_DIR, 32'hFFFF_FFFF);
        rd(0, RA_DIR, v);  chk("R3 dir upper bits read zero", v, 32'h000F_FFFF);
        chk("R2 dir drives pin_oe", {12'h0, oe_a}, 32'h000F_FFFF);
        wr(1, RA_DIR, 32'hFFFF_FFFF);
        rd(1, RA_DIR, v);  chk("R3 19-pin dir mask", v, 32'h0007_FFFF);
        wr(0, RA_OUT, 32'hFFF1_2345);
        chk("R2 out drives pin_out", {12'h0, out_a}, 32'h0001_2345);
        wr(0, RA_PULL, 32'h0000_0F0F);
        chk("R2 pull-up", {12'h0, pull_a}, 32'h0000_0F0F);
        wr(0, RA_ALTA, 32'h000A_0001);
        wr(0, RA_ALTB, 32'h0005_0002);
        chk("R2 alt A", {12'h0, alta_a}, 32'h000A_0001);
        chk("R2 alt B", {12'h0, altb_a}, 32'h0005_0002);
        rd(0, RA_ALTB, v); chk("R2 alt B readback", v, 32'h0005_0002);
        wr(0, RA_DIR, 32'h0000_0000);
        chk("R2 dir back to input", {12'h0, oe_a}, 32'h0);
    endtask

    task automatic t_input;
        logic [31:0] v;
        @(negedge clk);
        in_a = 20'hA5A5A;
        wait_n(1);
        rd(0, RA_IN, v); chk("R4 input not yet after one edge", v, 32'h0);
        wait_n(1);
        rd(0, RA_IN, v); chk("R4 input after two edges", v, 32'h000A_5A5A);
        wr(0, RA_IN, 32'h0);
        rd(0, RA_IN, v); chk("R4 write to input ignored", v, 32'h000A_5A5A);
        in_a = '0;
        wait_n(3);
        wr(0, RA_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_edges;
        logic [31:0] v;
        // mode 1 on pin 3, enabled
        wr(0, RA_TRG0, 32'h8);
        wr(0, RA_IENS, 32'h8);
        in_a[3] = 1'b1; wait_n(3);
        rd(0, RA_STAT, v); chk("R5 rising edge latched", v, 32'h8);
        chk("R9 irq on enabled event", {31'h0, irq_a}, 32'h1);
        in_a[3] = 1'b0; wait_n(3);
        rd(0, RA_STAT, v); chk("R7 latch held after level drops", v, 32'h8);
        wr(0, RA_STAT, 32'h0);
        rd(0, RA_STAT, v); chk("R7 write zero keeps status", v, 32'h8);
        wr(0, RA_STAT, 32'h8);
        rd(0, RA_STAT, v); chk("R7 write one clears status", v, 32'h0);
        chk("R9 irq drops after clear", {31'h0, irq_a}, 32'h0);
        // mode 2 on pin 4
        wr(0, RA_TRG0, 32'h0);
        wr(0, RA_TRG1, 32'h10);
        in_a[4] = 1'b1; wait_n(3);
        rd(0, RA_STAT, v); chk("R5 falling mode ignores rise", v, 32'h0);
        in_a[4] = 1'b0; wait_n(3);
        rd(0, RA_STAT, v); chk("R5 falling edge latched", v, 32'h10);
        wr(0, RA_STAT, 32'hFFFFF);
        // mode 3 on pin 5
        wr(0, RA_TRG0, 32'h20);
        wr(0, RA_TRG1, 32'h20);
        in_a[5] = 1'b1; wait_n(3);
        rd(0, RA_STAT, v); chk("R5 both mode rise", v, 32'h20);
        wr(0, RA_STAT, 32'h20);
        in_a[5] = 1'b0; wait_n(3);
        rd(0, RA_STAT, v); chk("R5 both mode fall", v, 32'h20);
        wr(0, RA_STAT, 32'hFFFFF);
    endtask

    task automatic t_levels;
        logic [31:0] v;
        // mode 5 on pin 6
        wr(0, RA_TRG1, 32'h0);
        wr(0, RA_TRG0, 32'h40);
        wr(0, RA_TLVL, 32'h40);
        rd(0, RA_STAT, v); chk("R6 high mode quiet while low", v, 32'h0);
        in_a[6] = 1'b1; wait_n(2);
        rd(0, RA_STAT, v); chk("R6 high level shown", v, 32'h40);
        in_a[6] = 1'b0; wait_n(2);
        rd(0, RA_STAT, v); chk("R6 level not latched", v, 32'h0);
        // mode 6 on pin 7
        wr(0, RA_TRG0, 32'h0);
        wr(0, RA_TRG1, 32'h80);
        wr(0, RA_TLVL, 32'h80);
        rd(0, RA_STAT, v); chk("R6 low level shown", v, 32'h80);
        in_a[7] = 1'b1; wait_n(2);
        rd(0, RA_STAT, v); chk("R6 low level gone when high", v, 32'h0);
        in_a[7] = 1'b0; wait_n(2);
        // mode 4 on pin 8
        wr(0, RA_TRG1, 32'h0);
        wr(0, RA_TLVL, 32'h100);
        in_a[8] = 1'b1; wait_n(3);
        rd(0, RA_STAT, v); chk("R6 mode 4 no event high", v, 32'h0);
        in_a[8] = 1'b0; wait_n(3);
        rd(0, RA_STAT, v); chk("R6 mode 4 no event low", v, 32'h0);
        wr(0, RA_TLVL, 32'h0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(0, RA_IENC, 32'hFFFF_FFFF);
        wr(0, RA_IENS, 32'h3);
        rd(0, RA_IENS, v); chk("R8 set ones", v, 32'h3);
        wr(0, RA_IENS, 32'h0);
        rd(0, RA_IENC, v); chk("R8 set with zeros no change", v, 32'h3);
        wr(0, RA_IENC, 32'h0);
        rd(0, RA_IENS, v); chk("R8 clear with zeros no change", v, 32'h3);
        wr(0, RA_IENC, 32'h1);
        rd(0, RA_IENS, v); chk("R8 clear one bit", v, 32'h2);
        // latched event on a disabled pin
        wr(0, RA_TRG0, 32'h8);
        in_a[3] = 1'b1; wait_n(3);
        rd(0, RA_STAT, v); chk("R9 event latched while disabled", v, 32'h8);
        chk("R9 no irq while disabled", {31'h0, irq_a}, 32'h0);
        wr(0, RA_IENS, 32'h8);
        chk("R9 irq once enabled", {31'h0, irq_a}, 32'h1);
        in_a[3] = 1'b0; wait_n(3);
        wr(0, RA_STAT, 32'hFFFFF);
        wr(0, RA_IENC, 32'hFFFFF);
        wr(0, RA_TRG0, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        cmd(5'd0, 3'd1, 1'b1);
        rd(0, RA_TRG0, v); chk("R10 number 0 to port0 pin7 mode", v, 32'h80);
        rd(0, RA_IENS, v); chk("R11 command sets enable", v, 32'h80);
        rd(1, RA_IENS, v); chk("R11 other port untouched", v, 32'h0);
        cmd(5'd10, 3'd2, 1'b1);
        rd(0, RA_TRG1, v); chk("R10 number 10 to pin17", v, 32'h2_0000);
        cmd(5'd16, 3'd5, 1'b1);
        rd(0, RA_TRG0, v); chk("R10 number 16 to pin19 bit0", v, 32'h8_0080);
        rd(0, RA_TLVL, v); chk("R10 number 16 to pin19 level", v, 32'hA_0000 & 32'h8_0000);
        rd(0, RA_IENS, v); chk("R11 enables accumulate", v, 32'hA_0080);
        cmd(5'd11, 3'd3, 1'b1);
        rd(1, RA_TRG0, v); chk("R10 number 11 to port1 pin18", v, 32'h4_0000);
        rd(1, RA_TRG1, v); chk("R10 number 11 mode bit1", v, 32'h4_0000);
        rd(0, RA_TRG0, v); chk("R11 port0 ignores port1 number", v, 32'h8_0080);
        cmd(5'd14, 3'd6, 1'b1);
        rd(1, RA_TLVL, v); chk("R10 number 14 to port1 pin15", v, 32'h8000);
        rd(1, RA_STAT, v); chk("R6 low level on mapped pin", v, 32'h8000);
        chk("R9 port1 irq from level", {31'h0, irq_b}, 32'h1);
        in_b[18] = 1'b1; wait_n(3);
        rd(1, RA_STAT, v); chk("R5 port1 edge on mapped pin", v, 32'h4_8000);
        cmd(5'd15, 3'd1, 1'b1);
        rd(1, RA_TRG0, v); chk("R11 pin19 absent on 19-pin port", v, 32'h4_0000);
        rd(1, RA_IENS, v); chk("R11 absent pin no enable", v, 32'h4_8000);
        rd(0, RA_TRG0, v); chk("R11 number 15 not port0", v, 32'h8_0080);
        cmd(5'd17, 3'd1, 1'b1);
        rd(0, RA_TRG0, v); chk("R10 number 17 invalid", v, 32'h8_0080);
        rd(0, RA_IENS, v); chk("R10 number 17 no enable", v, 32'hA_0080);
        cmd(5'd0, 3'd7, 1'b1);
        rd(0, RA_TRG1, v); chk("R11 mode 7 refused", v, 32'h2_0000);
        cmd(5'd0, 3'd2, 1'b1);
        rd(0, RA_TRG0, v); chk("R11 reprogram clears old bit0", v, 32'h8_0000);
        rd(0, RA_TRG1, v); chk("R11 reprogram sets bit1", v, 32'h2_0080);
        cmd(5'd0, 3'd0, 1'b0);
        rd(0, RA_IENS, v); chk("R11 disable clears only enable", v, 32'hA_0000);
        rd(0, RA_TRG1, v); chk("R11 disable keeps mode", v, 32'h2_0080);
        // command and bus write in the same cycle
        @(negedge clk);
        addr = RA_IENC; wdata = 32'h80; we_a = 1'b1;
        cfg_req = 1'b1; cfg_xint = 5'd0; cfg_mode = 3'd1; cfg_en = 1'b1;
        @(negedge clk);
        we_a = 1'b0; cfg_req = 1'b0;
        rd(0, RA_IENS, v); chk("R11 command beats bus clear", v, 32'hA_0080);
        rd(0, RA_TRG0, v); chk("R11 command mode applied", v, 32'h8_0080);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_input;
        t_edges;
        t_levels;
        t_enable;
        t_map;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run;
        end
    end
endmodule